// File: doc/BRIEF.md
# Pipelined 18-bit Floating-Point Multiplier

This block multiplies two numbers held in a compact 18-bit floating-point word. Bit 17 is the sign. Bits 16:10 hold a 7-bit exponent with a bias of 63. Bits 9:0 hold a 10-bit fraction, and a leading one is implied above it. The datapath is split into three register stages, so the block can take a new operand pair on every clock. A result leaves the block three clocks after its operands are accepted, together with a valid strobe.

The first stage checks both operands for zero, restores the hidden ones and adds the exponents into a register one bit wider than the exponent field. The second stage forms the 22-bit mantissa product and keeps only its upper 12 bits. In the same stage it corrects the exponent for a product of two or more. The third stage picks the fraction bits, applies the zero, underflow and overflow policies, and packs the output word. The block does no rounding and has no infinities, NaNs or denormals.

Top module: `fmul18_pipe`

## Requirements
- R1: A pair presented with `in_vld` high at a rising clock edge produces `out_vld` high exactly three rising edges later. `out_vld` is low three edges after a cycle with `in_vld` low. One pair is accepted on every clock.
- R2: For nonzero operands whose result stays in range, the result exponent field equals ea + eb − 63 + c, and the fraction field holds the 10 bits below the leading one of the product (1.fa)·(1.fb). Here c is 1 when that product is two or more and 0 otherwise.
- R3: An operand is zero when bits 16:0 are all zero. Any zero operand gives an all-zero result word, with the sign bit cleared.
- R4: For a nonzero result, bit 17 is the exclusive-or of the two operand sign bits.
- R5: When the biased result exponent from R2 is below 0, the result is the all-zero word.
- R6: When the biased result exponent from R2 is above 127, the result has exponent field 1111111 and fraction field all ones, and it keeps the sign from R4.
- R7: Product bits below the kept fraction are discarded by truncation. They are never used for rounding.
- R8: While `rst` is high at a rising edge, `out_vld` and `out_p` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand pair valid |
| op_a | input | 18 | First operand word |
| op_b | input | 18 | Second operand word |
| out_vld | output | 1 | Product valid, three clocks after `in_vld` |
| out_p | output | 18 | Product word |

## Verification
A wrong value in the registered exponent sum or in the kept product bits shows up in `out_p` exactly three clocks after the pair that caused it. A stage-two fault moves the output exponent by one, and a stage-three fault shifts the fraction by one bit. A fault in a flag or the valid chain shows as a wrong zero, a missing saturation or a valid strobe that arrives out of step. The bench streams one pair per clock across every pair of exponents, through long fraction sweeps and with gaps in the strobe. Because of this, a fault is seen on the very next affected result.

// File: rtl/fmul18_pipe.sv
module fmul18_pipe #(
  parameter int EW = 7,
  parameter int FW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [EW+FW:0]    op_a,
  input  logic [EW+FW:0]    op_b,
  output logic              out_vld,
  output logic [EW+FW:0]    out_p
);
  localparam int W    = 1 + EW + FW;
  localparam int MW   = FW + 1;
  localparam int PW   = 2 * MW;
  localparam int XW   = EW + 3;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int EMAX = (1 << EW) - 1;

  // stage 1: zero detect, hidden ones, exponent sum with carry
  logic          v1, sa1, sb1, z1;
  logic [EW:0]   esum1;
  logic [MW-1:0] ma1, mb1;

  wire za = (op_a[W-2:0] == '0);
  wire zb = (op_b[W-2:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; sa1 <= 1'b0; sb1 <= 1'b0; z1 <= 1'b0;
      esum1 <= '0; ma1 <= '0; mb1 <= '0;
    end else begin
      v1    <= in_vld;
      sa1   <= op_a[W-1];
      sb1   <= op_b[W-1];
      z1    <= za | zb;
      esum1 <= {1'b0, op_a[W-2:FW]} + {1'b0, op_b[W-2:FW]};
      ma1   <= {~za, op_a[FW-1:0]};
      mb1   <= {~zb, op_b[FW-1:0]};
    end
  end

  // stage 2: mantissa product, keep top MW+1 bits, exponent correction
  logic          v2, sg2, z2;
  logic [XW-1:0] ex2;
  logic [MW:0]   fr2;

  wire [PW-1:0] prod = PW'(ma1) * PW'(mb1);
  wire [XW-1:0] ex_n = {2'b00, esum1} - XW'(BIAS) + XW'(prod[PW-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0; sg2 <= 1'b0; z2 <= 1'b0; ex2 <= '0; fr2 <= '0;
    end else begin
      v2  <= v1;
      sg2 <= sa1 ^ sb1;
      z2  <= z1;
      ex2 <= ex_n;
      fr2 <= prod[PW-1 -: MW+1];
    end
  end

  // stage 3: normalize, flush, saturate, pack
  wire          uf   = ex2[XW-1];
  wire          of   = ~ex2[XW-1] & (ex2[XW-2:EW] != '0);
  wire [FW-1:0] frac = fr2[MW] ? fr2[MW-1:1] : fr2[MW-2:0];
  logic [W-1:0] res;

  always_comb begin
    if (z2 || uf)  res = '0;
    else if (of)   res = {sg2, {EW{1'b1}}, {FW{1'b1}}};
    else           res = {sg2, ex2[EW-1:0], frac};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_p   <= '0;
    end else begin
      out_vld <= v2;
      out_p   <= res;
    end
  end

  // cycles since reset, for the checks below
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 3)  age <= age + 2'd1;
  end

  wire [EW:0] in_esum = {1'b0, op_a[W-2:FW]} + {1'b0, op_b[W-2:FW]};

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (age == 3) |-> (out_vld == $past(in_vld, 3)));

  p_zero_op_r3: assert property (@(posedge clk) disable iff (rst)
    (age == 3) && $past(in_vld && (za || zb), 3) |-> (out_p == '0));

  p_sign_r4: assert property (@(posedge clk) disable iff (rst)
    (age == 3) && out_vld && (out_p[W-2:0] != '0)
      |-> (out_p[W-1] == $past(op_a[W-1] ^ op_b[W-1], 3)));

  p_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    (age == 3) && $past(in_vld && !za && !zb && (int'(in_esum) < BIAS - 1), 3)
      |-> (out_p == '0));

  p_saturate_r6: assert property (@(posedge clk) disable iff (rst)
    (age == 3) && $past(in_vld && !za && !zb && (int'(in_esum) > BIAS + EMAX), 3)
      |-> (out_p[W-2:0] == {(W-1){1'b1}}));
endmodule

// File: tb/fmul18_pipe_test.sv
`timescale 1ns/1ps
module fmul18_pipe_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, in_vld;
  logic [17:0] op_a, op_b;
  wire         out_vld;
  wire  [17:0] out_p;

  fmul18_pipe uut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .out_vld(out_vld), .out_p(out_p)
  );

  int vectors = 0;
  int miscompares = 0;
  logic [17:0] h_e [3];
  logic        h_v [3];
  string       h_t [3];
  logic [31:0] seed = 32'h1234_5678;

  function automatic int exp_of(input logic [17:0] a, input logic [17:0] b,
                                output logic [21:0] p);
    int ea, eb;
    ea = a[16:10]; eb = b[16:10];
    p  = {1'b1, a[9:0]} * {1'b1, b[9:0]};
    return ea + eb - 63 + (p[21] ? 1 : 0);
  endfunction

  function automatic logic [17:0] model(input logic [17:0] a, input logic [17:0] b);
    logic [21:0] p;
    int e;
    logic s;
    if (a[16:0] == 0 || b[16:0] == 0) return 18'h0;
    e = exp_of(a, b, p);
    s = a[17] ^ b[17];
    if (e < 0)   return 18'h0;
    if (e > 127) return {s, 7'h7F, 10'h3FF};
    return {s, e[6:0], (p[21] ? p[20:11] : p[19:10])};
  endfunction

  function automatic string tag(input logic [17:0] a, input logic [17:0] b);
    logic [21:0] p;
    int e;
    if (a[16:0] == 0 || b[16:0] == 0) return "R3";
    e = exp_of(a, b, p);
    if (e < 0)   return "R5";
    if (e > 127) return "R6";
    if (p[21] ? (p[10:0] != 0) : (p[9:0] != 0)) return "R7";
    return "R2";
  endfunction

  task automatic step(input logic v, input logic [17:0] a, input logic [17:0] b);
    @(negedge clk);
    op_a = a; op_b = b; in_vld = v;
    h_e[2] = h_e[1]; h_v[2] = h_v[1]; h_t[2] = h_t[1];
    h_e[1] = h_e[0]; h_v[1] = h_v[0]; h_t[1] = h_t[0];
    h_e[0] = model(a, b); h_v[0] = v; h_t[0] = tag(a, b);
    @(posedge clk); #1;
    vectors++;
    if (out_vld !== h_v[2]) begin
      miscompares++;
      $display("FAIL R1: out_vld got %b expected %b", out_vld, h_v[2]);
    end
    if (h_v[2]) begin
      vectors++;
      if (out_p !== h_e[2]) begin
        miscompares++;
        if ((out_p ^ h_e[2]) == 18'h20000)
          $display("FAIL R4: out_p got %h expected %h", out_p, h_e[2]);
        else
          $display("FAIL %s: out_p got %h expected %h", h_t[2], out_p, h_e[2]);
      end
    end
  endtask

  function automatic logic [31:0] next(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    repeat (250000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run got no end expected end");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin h_e[i] = '0; h_v[i] = 1'b0; h_t[i] = "R1"; end
    rst = 1'b1; in_vld = 1'b1; op_a = 18'h0FC00; op_b = 18'h0FC00;
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if (out_vld !== 1'b0 || out_p !== 18'h0) begin
      miscompares++;
      $display("FAIL R8: got %b/%h expected 0/00000", out_vld, out_p);
    end
    @(negedge clk);
    rst = 1'b0; in_vld = 1'b0;

    // corners: 1.0*1.0, max*max, zero operands, truncation, boundaries
    step(1'b1, 18'h0FC00, 18'h0FC00);          // R2: 1.0 * 1.0
    step(1'b1, 18'h3FFFF, 18'h1FFFF);          // R6: max * max, negative
    step(1'b1, 18'h00000, 18'h1FFFF);          // R3
    step(1'b1, 18'h20000, 18'h0FC00);          // R3: negative zero operand
    step(1'b1, 18'h0FFFF, 18'h0FFFF);          // R7: all-ones fractions
    step(1'b1, 18'h00000 | 18'h00001, 18'h0F800); // R5: tiny times 0.5
    step(1'b1, 18'h00400, 18'h0FC00);          // biased exponent 1 times 1.0
    step(1'b0, 18'h0FC00, 18'h0FC00);          // R1: gap
    step(1'b1, 18'h2FC00, 18'h0FC00);          // R4: sign
    step(1'b1, 18'h1FC00, 18'h10000);          // exponent 127 + 64 - 63 = 128 -> R6

    // every exponent pair, pseudo-random fractions and signs, strobe gaps
    for (int ea = 0; ea < 128; ea++) begin
      for (int eb = 0; eb < 128; eb++) begin
        logic [17:0] a, b;
        seed = next(seed);
        a = {seed[31], 7'(ea), seed[9:0]};
        b = {seed[30], 7'(eb), seed[25:16]};
        if (ea == 0 && eb[0]) a[9:0] = 10'h0;
        step(seed[13:11] != 3'b000, a, b);
      end
    end

    // fraction sweep around unity exponents
    for (int fa = 0; fa < 1024; fa++) begin
      for (int fb = 0; fb < 1024; fb += 17) begin
        step(1'b1, {fa[0], 7'd63, 10'(fa)}, {1'b0, 7'd64, 10'(fb)});
      end
    end

    for (int i = 0; i < 3; i++) step(1'b0, 18'h0, 18'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule